// File: doc/BRIEF.md
# Dual 40-bit Accumulator Arithmetic Unit

This block holds two signed accumulators, 40 bits wide by default. It carries out add, subtract, compare, increment, decrement, negate, absolute value and move on them. One operation is accepted per clock while `op_valid` is high. The named accumulator and the four condition flags (carry, overflow, zero, sign) are updated on that clock edge. Compare updates only the flags.

An operand can come from several places: the other accumulator, one of two 32-bit secondary registers used whole, the upper or lower 16-bit half of a secondary register, a 40-bit product value, a 16-bit immediate, or an 8-bit short immediate. Any operand of 16 bits or fewer is first sign-extended and then shifted left by 16, so it lines up with the middle field of the accumulator. The exception is the add-low operation, which zero-extends a low half and adds it at bit 0. The result always wraps to 40 bits.

Top module: `acc_arith_unit`

## Requirements
- R1: Operation codes on `op_code` are: 0 none, 1 add, 2 subtract, 3 compare, 4 add-low, 5 middle increment, 6 middle decrement, 7 increment, 8 decrement, 9 negate, 10 absolute value, 11 move. Codes 12 to 15 behave as code 0. Operand sources on `src_sel` are: 0 the other accumulator; 1 the whole 32-bit secondary register chosen by `sec_idx`, sign-extended and applied at bit 0; 2 that register's bits 31:16; 3 that register's bits 15:0; 4 `prod`; 5 `imm`; 6 `imm[7:0]`; 7 zero. Sources 2, 3, 5 and 6 are sign-extended and shifted left by 16. Add writes the accumulator plus the operand.
- R2: Subtract writes the accumulator minus the operand, wrapped to 40 bits.
- R3: On add-type operations (1, 4, 5, 7), carry is the unsigned carry out of bit 39. On subtract-type operations (2, 3, 6, 8), carry is 1 exactly when no borrow occurs, meaning the accumulator is unsigned greater than or equal to the operand.
- R4: Overflow is 1 when the two addends share bit 39 and the result's bit 39 differs from it. For subtraction the subtrahend is taken inverted.
- R5: Compare computes the subtraction and its four flags but leaves both accumulators unchanged.
- R6: Middle increment and middle decrement add or subtract 0x10000. Plain increment and plain decrement add or subtract 1.
- R7: Add-low zero-extends bits 15:0 of the selected secondary register and adds them at bit 0.
- R8: Move copies the selected operand into the accumulator. A 16-bit half lands sign-extended in bits 39:16, with bits 15:0 cleared.
- R9: Negate writes 0 minus the accumulator. Absolute value negates only when bit 39 is set, so the most negative value returns unchanged. Negate, absolute value and move clear carry and overflow.
- R10: Zero and sign flags describe the 40-bit result. Only the accumulator named by `dst_sel` is written. With `op_valid` low, or with code 0, accumulators and flags hold.
- R11: After reset both accumulators and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Execute the operation this cycle |
| op_code | input | 4 | Operation code |
| dst_sel | input | 1 | Accumulator being operated on |
| src_sel | input | 3 | Operand source |
| sec_idx | input | 1 | Secondary register select |
| imm | input | 16 | Immediate; low 8 bits form the short immediate |
| sec0 | input | 32 | Secondary register 0 |
| sec1 | input | 32 | Secondary register 1 |
| prod | input | 40 | Product value |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| flag_c | output | 1 | Carry / no-borrow |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_s | output | 1 | Result bit 39 |

## Verification
The bench uses the default widths: a 40-bit accumulator, 16-bit halves and an 8-bit short immediate. At these widths a 40-bit product operand can load the largest positive value, so one increment from there crosses into the negative range and shows signed overflow at bit 39. The 16-bit alignment puts the middle-field cases within reach: a short immediate of -1, and a decrement from 0x10000 down to exactly zero. The same widths also cover absolute value of the most negative value, and an add-low of a low half whose top bit is set, which would change the result if it were sign-extended.

// File: rtl/acc_arith_unit.sv
module acc_arith_unit #(
  parameter int ACC_W   = 40,
  parameter int HALF_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [3:0]          op_code,
  input  logic                dst_sel,
  input  logic [2:0]          src_sel,
  input  logic                sec_idx,
  input  logic [HALF_W-1:0]   imm,
  input  logic [2*HALF_W-1:0] sec0,
  input  logic [2*HALF_W-1:0] sec1,
  input  logic [ACC_W-1:0]    prod,
  output logic [ACC_W-1:0]    acc0,
  output logic [ACC_W-1:0]    acc1,
  output logic                flag_c,
  output logic                flag_v,
  output logic                flag_z,
  output logic                flag_s
);
  localparam int SEC_W = 2 * HALF_W;
  localparam int MSB   = ACC_W - 1;

  localparam logic [3:0] OP_ADD  = 4'd1, OP_SUB  = 4'd2, OP_CMP = 4'd3, OP_ADDL = 4'd4;
  localparam logic [3:0] OP_INCM = 4'd5, OP_DECM = 4'd6, OP_INC = 4'd7, OP_DEC  = 4'd8;
  localparam logic [3:0] OP_NEG  = 4'd9, OP_ABS  = 4'd10, OP_MOV = 4'd11;

  function automatic logic [ACC_W-1:0] mid_align(input logic [HALF_W-1:0] h);
    return {{(ACC_W-SEC_W){h[HALF_W-1]}}, h, {HALF_W{1'b0}}};
  endfunction

  logic [ACC_W-1:0] acc_q [2];
  logic [SEC_W-1:0] sec;
  logic [ACC_W-1:0] a, opnd, b, bb, res;
  logic [ACC_W:0]   sum;
  logic             is_sub, arith, wr, upd, c_n, v_n;

  assign sec = sec_idx ? sec1 : sec0;
  assign a   = acc_q[dst_sel];

  always_comb begin
    case (src_sel)
      3'd0:    opnd = acc_q[~dst_sel];
      3'd1:    opnd = {{(ACC_W-SEC_W){sec[SEC_W-1]}}, sec};
      3'd2:    opnd = mid_align(sec[SEC_W-1:HALF_W]);
      3'd3:    opnd = mid_align(sec[HALF_W-1:0]);
      3'd4:    opnd = prod;
      3'd5:    opnd = mid_align(imm);
      3'd6:    opnd = mid_align({{(HALF_W-SHORT_W){imm[SHORT_W-1]}}, imm[SHORT_W-1:0]});
      default: opnd = '0;
    endcase
  end

  always_comb begin
    b = opnd; is_sub = 1'b0; arith = 1'b1; wr = 1'b1; upd = 1'b1;
    case (op_code)
      OP_ADD:  ;
      OP_SUB:  is_sub = 1'b1;
      OP_CMP:  begin is_sub = 1'b1; wr = 1'b0; end
      OP_ADDL: b = {{(ACC_W-HALF_W){1'b0}}, sec[HALF_W-1:0]};
      OP_INCM: b = ACC_W'(1) << HALF_W;
      OP_DECM: begin b = ACC_W'(1) << HALF_W; is_sub = 1'b1; end
      OP_INC:  b = ACC_W'(1);
      OP_DEC:  begin b = ACC_W'(1); is_sub = 1'b1; end
      OP_NEG, OP_ABS, OP_MOV: arith = 1'b0;
      default: begin arith = 1'b0; wr = 1'b0; upd = 1'b0; end
    endcase
  end

  assign bb  = is_sub ? ~b : b;
  assign sum = {1'b0, a} + {1'b0, bb} + {{ACC_W{1'b0}}, is_sub};

  always_comb begin
    res = sum[MSB:0];
    c_n = sum[ACC_W];
    v_n = (a[MSB] == bb[MSB]) && (sum[MSB] != a[MSB]);
    if (!arith) begin
      c_n = 1'b0;
      v_n = 1'b0;
      case (op_code)
        OP_NEG:  res = '0 - a;
        OP_ABS:  res = a[MSB] ? '0 - a : a;
        default: res = opnd;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q[0] <= '0;
      acc_q[1] <= '0;
      {flag_c, flag_v, flag_z, flag_s} <= '0;
    end else if (op_valid && upd) begin
      if (wr) acc_q[dst_sel] <= res;
      flag_c <= c_n;
      flag_v <= v_n;
      flag_z <= (res == '0);
      flag_s <= res[MSB];
    end
  end

  assign acc0 = acc_q[0];
  assign acc1 = acc_q[1];

  a_r5_cmp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_CMP |=> $stable(acc0) && $stable(acc1));

  a_r10_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !dst_sel |=> $stable(acc1));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc0) && $stable(acc1) && $stable({flag_c, flag_v, flag_z, flag_s}));

  a_r9_cv_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_NEG || op_code == OP_ABS || op_code == OP_MOV) |=> !flag_c && !flag_v);

  a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_INC && !dst_sel |=> acc0 == $past(acc0) + ACC_W'(1));

  a_r10_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !dst_sel && (op_code == OP_ADD || op_code == OP_SUB || op_code == OP_MOV)
    |=> flag_z == (acc0 == '0) && flag_s == acc0[MSB]);
endmodule

// File: tb/test_acc_arith_unit.sv
module test_acc_arith_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        dst_sel = 1'b0;
  logic [2:0]  src_sel = '0;
  logic        sec_idx = 1'b0;
  logic [15:0] imm = '0;
  logic [31:0] sec0 = '0, sec1 = '0;
  logic [39:0] prod = '0;
  logic [39:0] acc0, acc1;
  logic        flag_c, flag_v, flag_z, flag_s;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  acc_arith_unit i_acc_arith_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .dst_sel(dst_sel),
    .src_sel(src_sel), .sec_idx(sec_idx), .imm(imm), .sec0(sec0), .sec1(sec1), .prod(prod),
    .acc0(acc0), .acc1(acc1), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_s(flag_s));

  task automatic run_op(input logic [3:0] op, input logic d, input logic [2:0] s,
                        input logic si, input logic [15:0] im);
    @(negedge clk);
    op_code = op; dst_sel = d; src_sel = s; sec_idx = si; imm = im; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [39:0] e0, input logic [39:0] e1,
                     input logic [3:0] ef);
    total++;
    if (acc0 !== e0 || acc1 !== e1 || {flag_c, flag_v, flag_z, flag_s} !== ef) begin
      bad++;
      $display("FAIL %s: acc0=%h acc1=%h cvzs=%b expected acc0=%h acc1=%h cvzs=%b",
               tag, acc0, acc1, {flag_c, flag_v, flag_z, flag_s}, e0, e1, ef);
    end
  endtask

  task automatic t_reset();
    chk("R11 reset", 40'h0, 40'h0, 4'b0000);
  endtask

  task automatic t_move();
    sec0 = 32'h8000_0000; sec1 = 32'hABCD_1234;
    run_op(4'd11, 1'b0, 3'd1, 1'b0, 16'h0);
    chk("R8 move whole secondary", 40'hFF_8000_0000, 40'h0, 4'b0001);
    run_op(4'd11, 1'b0, 3'd2, 1'b1, 16'h0);
    chk("R8 move high half", 40'hFF_ABCD_0000, 40'h0, 4'b0001);
    run_op(4'd11, 1'b0, 3'd3, 1'b1, 16'h0);
    chk("R8 move low half", 40'h00_1234_0000, 40'h0, 4'b0000);
  endtask

  task automatic t_add();
    run_op(4'd1, 1'b0, 3'd6, 1'b0, 16'h55FF);
    chk("R1 R3 add short imm", 40'h00_1233_0000, 40'h0, 4'b1000);
    sec0 = 32'hFFFF_FFFF;
    run_op(4'd1, 1'b0, 3'd1, 1'b0, 16'h0);
    chk("R1 add secondary at bit0", 40'h00_1232_FFFF, 40'h0, 4'b1000);
  endtask

  task automatic t_overflow_abs();
    prod = 40'h7F_FFFF_FFFF;
    run_op(4'd11, 1'b1, 3'd4, 1'b0, 16'h0);
    chk("R8 move product", 40'h00_1232_FFFF, 40'h7F_FFFF_FFFF, 4'b0000);
    run_op(4'd7, 1'b1, 3'd0, 1'b0, 16'h0);
    chk("R4 R6 inc overflow", 40'h00_1232_FFFF, 40'h80_0000_0000, 4'b0101);
    run_op(4'd10, 1'b1, 3'd0, 1'b0, 16'h0);
    chk("R9 abs most negative", 40'h00_1232_FFFF, 40'h80_0000_0000, 4'b0001);
  endtask

  task automatic t_neg_dec();
    run_op(4'd11, 1'b0, 3'd5, 1'b0, 16'h0001);
    chk("R8 move imm", 40'h00_0001_0000, 40'h80_0000_0000, 4'b0000);
    run_op(4'd9, 1'b0, 3'd0, 1'b0, 16'h0);
    chk("R9 negate", 40'hFF_FFFF_0000, 40'h80_0000_0000, 4'b0001);
    run_op(4'd10, 1'b0, 3'd0, 1'b0, 16'h0);
    chk("R9 abs negative", 40'h00_0001_0000, 40'h80_0000_0000, 4'b0000);
    run_op(4'd6, 1'b0, 3'd0, 1'b0, 16'h0);
    chk("R6 R3 R10 mid decrement to zero", 40'h0, 40'h80_0000_0000, 4'b1010);
    run_op(4'd8, 1'b0, 3'd0, 1'b0, 16'h0);
    chk("R6 R3 decrement borrow", 40'hFF_FFFF_FFFF, 40'h80_0000_0000, 4'b0001);
  endtask

  task automatic t_sub();
    run_op(4'd2, 1'b0, 3'd0, 1'b0, 16'h0);
    chk("R2 subtract other acc", 40'h7F_FFFF_FFFF, 40'h80_0000_0000, 4'b1000);
    run_op(4'd2, 1'b1, 3'd0, 1'b0, 16'h0);
    chk("R2 R4 subtract overflow", 40'h7F_FFFF_FFFF, 40'h00_0000_0001, 4'b1100);
  endtask

  task automatic t_cmp();
    run_op(4'd3, 1'b0, 3'd5, 1'b0, 16'h7FFF);
    chk("R5 compare imm", 40'h7F_FFFF_FFFF, 40'h00_0000_0001, 4'b1000);
    run_op(4'd3, 1'b1, 3'd0, 1'b0, 16'h0);
    chk("R5 compare borrow", 40'h7F_FFFF_FFFF, 40'h00_0000_0001, 4'b0001);
  endtask

  task automatic t_addl_incm();
    sec1 = 32'h0000_8001;
    run_op(4'd4, 1'b1, 3'd0, 1'b1, 16'h0);
    chk("R7 add-low zero extend", 40'h7F_FFFF_FFFF, 40'h00_0000_8002, 4'b0000);
    run_op(4'd5, 1'b1, 3'd0, 1'b0, 16'h0);
    chk("R6 mid increment", 40'h7F_FFFF_FFFF, 40'h00_0001_8002, 4'b0000);
  endtask

  task automatic t_idle_dst();
    @(negedge clk);
    op_code = 4'd7; dst_sel = 1'b1; op_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle holds", 40'h7F_FFFF_FFFF, 40'h00_0001_8002, 4'b0000);
    run_op(4'd13, 1'b1, 3'd0, 1'b0, 16'h0);
    chk("R1 R10 unused code holds", 40'h7F_FFFF_FFFF, 40'h00_0001_8002, 4'b0000);
    prod = 40'h00_0000_0001;
    run_op(4'd1, 1'b0, 3'd4, 1'b0, 16'h0);
    chk("R1 R10 add product dst only", 40'h80_0000_0000, 40'h00_0001_8002, 4'b0101);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: expected completion, got timeout");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_move();
    t_add();
    t_overflow_abs();
    t_neg_dec();
    t_sub();
    t_cmp();
    t_addl_incm();
    t_idle_dst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule